// File: doc/BRIEF.md
# Horizontal Drive Soft-Start Generator

This block produces the horizontal output drive pulse train while the deflection stage powers up. After a start request the first pulse is high for a single clock period. Each low interval lasts the full nominal off-time, so the first drive period is far shorter than nominal and the pulse rate starts near twice the normal line rate. The high time then grows by one clock period after every `STEP_CYCLES` drive periods, until it reaches the nominal on-time. The high time never goes past that value.

The first pulse with nominal width raises `ramp_done`. When that pulse ends, `loop_close` rises and tells the phase loop that it may take over. By then the period is already at its nominal value, so the loop only needs small corrections. Dropping the start request stops the drive at once and returns the ramp to its one-cycle starting point. `STEP_CYCLES` is chosen so that the whole ramp spans about 160 ms at the system clock rate.

The controller is a three-state machine:
- `HS_IDLE`: the drive is held low.
- `HS_ON`: the drive is high.
- `HS_OFF`: the drive is low.

Its transitions are:
- *launch*: `HS_IDLE` to `HS_ON`, when start is seen.
- *on-expire*: `HS_ON` to `HS_OFF`, when the high count is used up.
- *off-expire*: `HS_OFF` to `HS_ON`, when the low count is used up; this transition also advances the ramp.
- *abort*: any state to `HS_IDLE`, when start is low.

Top module: `hdrive_softstart`

## Requirements
- R1: While reset is asserted and afterwards until a start request, `drive_out`, `ramp_done` and `loop_close` are 0.
- R2: After `start_req` is sampled high in idle, `drive_out` is 1 from the next clock edge, and the first high interval lasts exactly one clock.
- R3: Every low interval of the drive lasts exactly `off_nom` clocks (`off_nom` >= 1).
- R4: Drive period c (counting from 0) is high for 1 + floor(c / STEP_CYCLES) clocks until limited by R5.
- R5: The high time never exceeds max(`on_nom`, 1) clocks; once it reaches that value, it stays there.
- R6: `ramp_done` becomes 1 on the same edge on which the first nominal-width pulse starts, and it stays 1 while `start_req` stays high.
- R7: `loop_close` becomes 1 on the edge on which the first nominal-width pulse ends, and it stays 1 while `start_req` stays high; it is never 1 while `ramp_done` is 0.
- R8: When `start_req` is sampled low, all three outputs are 0 from the next edge. A later start begins again with a one-clock pulse.
- R9: With `on_nom` <= 1, the very first pulse is already nominal, so `ramp_done` rises together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Held high to run the soft start and the drive |
| on_nom | input | CNT_W | Nominal high time in clocks |
| off_nom | input | CNT_W | Low time in clocks, used throughout |
| drive_out | output | 1 | Horizontal drive pulse |
| ramp_done | output | 1 | The high time has reached nominal |
| loop_close | output | 1 | Permission for the phase loop to close |

## Verification
All three outputs come from registers and move one clock edge after the input that causes them. A launch or an abort appears on the first rising edge after `start_req` changes. The bench changes inputs and samples outputs on falling edges only. It therefore judges every edge's result half a clock after that edge.

A cycle-by-cycle expected waveform is built from the R4 formula and the R5 cap. It is compared at each falling edge: one sample per clock for the high and low intervals, together with both flags. Directed cases cover an abort in the middle of a pulse, a restart, reset during a run, and `on_nom` of 0 and 1.

// File: rtl/hss_pkg.sv
package hss_pkg;
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_ON   = 2'd1,
        HS_OFF  = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hss_phase_timer.sv
module hss_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             at_end
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= CNT_W'(1);
        else if (restart)
            count <= CNT_W'(1);
        else
            count <= count + 1'b1;
    end

    assign at_end = (count >= limit);

    // R3
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count != '0);
endmodule

// File: rtl/hss_ramp.sv
module hss_ramp #(
    parameter int CNT_W       = 16,
    parameter int STEP_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] on_nom,
    output logic [CNT_W-1:0] on_len,
    output logic [CNT_W-1:0] on_len_nx
);
    localparam int SW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYCLES - 1);

    logic [SW-1:0] step_cnt;
    logic [SW-1:0] step_nx;

    always_comb begin
        on_len_nx = on_len;
        step_nx   = step_cnt;
        if (clear) begin
            on_len_nx = CNT_W'(1);
            step_nx   = '0;
        end else if (advance) begin
            if (step_cnt == STEP_LAST) begin
                step_nx = '0;
                if (on_len < on_nom)
                    on_len_nx = on_len + 1'b1;
            end else begin
                step_nx = step_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_len   <= CNT_W'(1);
            step_cnt <= '0;
        end else begin
            on_len   <= on_len_nx;
            step_cnt <= step_nx;
        end
    end

    // R5
    on_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_len <= on_nom) || (on_len == CNT_W'(1)));

    // R4
    on_len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_len != $past(on_len)) |-> ((on_len == $past(on_len) + 1'b1) || (on_len == CNT_W'(1))));
endmodule

// File: rtl/hdrive_softstart.sv
module hdrive_softstart
    import hss_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int STEP_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] on_nom,
    input  logic [CNT_W-1:0] off_nom,
    output logic             drive_out,
    output logic             ramp_done,
    output logic             loop_close
);
    hs_state_e        state, state_nx;
    logic             at_end;
    logic             tmr_restart;
    logic [CNT_W-1:0] tmr_limit;
    logic [CNT_W-1:0] on_len, on_len_nx;
    logic             ramp_clear, ramp_adv;
    logic             launch_edge, on_expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= HS_IDLE;
        else
            state <= state_nx;
    end

    // transitions: launch, on-expire, off-expire, abort
    always_comb begin
        state_nx = state;
        if (!start_req) begin
            state_nx = HS_IDLE;
        end else begin
            unique case (state)
                HS_IDLE: state_nx = HS_ON;
                HS_ON:   state_nx = at_end ? HS_OFF : HS_ON;
                HS_OFF:  state_nx = at_end ? HS_ON : HS_OFF;
                default: state_nx = HS_IDLE;
            endcase
        end
    end

    assign tmr_limit   = (state == HS_ON) ? on_len : off_nom;
    assign tmr_restart = (state == HS_IDLE) || at_end;
    assign ramp_clear  = !start_req || (state == HS_IDLE);
    assign ramp_adv    = start_req && (state == HS_OFF) && at_end;
    assign launch_edge = (state_nx == HS_ON) && (state != HS_ON);
    assign on_expire   = start_req && (state == HS_ON) && at_end;

    hss_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .limit   (tmr_limit),
        .at_end  (at_end)
    );

    hss_ramp #(.CNT_W(CNT_W), .STEP_CYCLES(STEP_CYCLES)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ramp_clear),
        .advance   (ramp_adv),
        .on_nom    (on_nom),
        .on_len    (on_len),
        .on_len_nx (on_len_nx)
    );

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_done  <= 1'b0;
            loop_close <= 1'b0;
        end else if (!start_req) begin
            ramp_done  <= 1'b0;
            loop_close <= 1'b0;
        end else begin
            if (launch_edge && (on_len_nx >= on_nom))
                ramp_done <= 1'b1;
            if (on_expire && ramp_done)
                loop_close <= 1'b1;
        end
    end

    assign drive_out = (state == HS_ON);

    // R8
    abort_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_req |=> (!drive_out && !ramp_done && !loop_close));

    // R7
    close_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_close |-> ramp_done);

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_done && start_req) |=> ramp_done);

    // R2
    launch_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_out) |-> $past(start_req));
endmodule

// File: tb/hdrive_softstart_test.sv
module hdrive_softstart_test;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int STEP       = 2;
    localparam int NVEC       = 6;
    // each row: on_nom, off_nom, drive periods to walk
    localparam int VEC [0:NVEC-1][0:2] = '{
        '{3, 2, 8}, '{5, 1, 12}, '{1, 3, 3},
        '{4, 4, 10}, '{2, 1, 6}, '{0, 2, 3}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_req = 1'b0;
    logic [W-1:0] on_nom = '0;
    logic [W-1:0] off_nom = W'(1);
    logic         drive_out, ramp_done, loop_close;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdrive_softstart #(.CNT_W(W), .STEP_CYCLES(STEP)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .on_nom     (on_nom),
        .off_nom    (off_nom),
        .drive_out  (drive_out),
        .ramp_done  (ramp_done),
        .loop_close (loop_close)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "drive", int'(drive_out), 0);
        chk(req, "done", int'(ramp_done), 0);
        chk(req, "close", int'(loop_close), 0);
    endtask

    // walk a full soft start from launch, comparing every clock (R2..R7, R9)
    task automatic walk(input int on_n, input int off_n, input int ncyc);
        int  cap;
        bit  done_e;
        bit  close_e;
        cap = (on_n < 1) ? 1 : on_n;
        done_e = 1'b0;
        close_e = 1'b0;
        on_nom = W'(on_n);
        off_nom = W'(off_n);
        start_req = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            int len;
            len = 1 + c / STEP;
            if (len > cap) len = cap;
            if (len == cap) done_e = 1'b1;
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                chk((c == 0) ? "R2" : ((len == cap) ? "R5" : "R4"), "drive high", int'(drive_out), 1);
                chk((cap == 1) ? "R9" : "R6", "ramp_done", int'(ramp_done), int'(done_e));
                chk("R7", "loop_close in high", int'(loop_close), int'(close_e));
            end
            if (done_e) close_e = 1'b1;
            for (int i = 0; i < off_n; i++) begin
                @(negedge clk);
                chk("R3", "drive low", int'(drive_out), 0);
                chk("R7", "loop_close in low", int'(loop_close), int'(close_e));
            end
        end
    endtask

    initial begin
        for (int n = 0; n < 200000; n++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2 + 1);
        chk_idle("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_idle("R1");

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            walk(VEC[v][0], VEC[v][1], VEC[v][2]);
            start_req = 1'b0;
            @(negedge clk);
            chk_idle("R8");
            @(negedge clk);
            chk_idle("R8");
        end

        // R8: abort in the middle of a long pulse, then restart
        on_nom = W'(6);
        off_nom = W'(1);
        start_req = 1'b1;
        for (int i = 0; i < 14; i++) @(negedge clk);
        for (int i = 0; i < 10 && !drive_out; i++) @(negedge clk);
        chk("R8", "in high before abort", int'(drive_out), 1);
        start_req = 1'b0;
        @(negedge clk);
        chk_idle("R8");
        start_req = 1'b1;
        @(negedge clk);
        chk("R8", "restart high", int'(drive_out), 1);
        @(negedge clk);
        chk("R8", "restart width one", int'(drive_out), 0);

        // R1: reset during a run clears everything
        for (int i = 0; i < 5; i++) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_idle("R1");
        start_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // R9: on_nom of one after reset
        walk(1, 2, 2);
        start_req = 1'b0;
        @(negedge clk);
        chk_idle("R8");

        finish_run();
    end
endmodule